// File: doc/BRIEF.md
# Page-Granular Region Address Translator

The block maps 32-bit logical addresses onto a wider physical address space. Software programs a small set of regions, each described by an inclusive range of logical pages, a page-unit add value, a set of per-bit attribute overrides and a free general-purpose byte. The page size is 2^PAGE_EXP bytes and there are 2^REGION_EXP regions, with at most 32.

A lookup presents a logical address and a byte of incoming bus attribute bits. The same cycle, the block returns a hit flag, the translated address, the modified attribute bits and the region's general-purpose byte. The first enabled region whose range contains the address's page supplies these values. When a valid lookup matches no enabled region, the block raises a sticky error status and captures the failing address. If the error interrupt is enabled, the status also drives an interrupt line.

Configuration uses a flat 32-bit word-addressed register space with single-cycle writes and combinational reads.

Top module: `atu_top`

## Requirements
- R1: The read-only word at 0x000 returns PAGE_EXP in bits 7:4 and REGION_EXP in bits 2:0, with all other bits zero. After reset, every writable register and the status read as zero, and `hit` and `irq` are low.
- R2: Bit n of the word at 0x004 enables region n. A disabled region never matches, whatever its bounds.
- R3: The page of a lookup is lookupAddr >> PAGE_EXP. A region matches when start page <= page <= end page, with both bounds included. Start pages are held at 0x020+4n and end pages at 0x0A0+4n, and they read back as written (the low 32-PAGE_EXP bits).
- R4: When several enabled regions match, the lowest-numbered region supplies all outputs.
- R5: The add value is {high word at 0x1A0+4n, low word at 0x120+4n}. `physAddr` equals lookupAddr + (add value << PAGE_EXP), taken modulo 2^PA_W, so an all-ones add value subtracts one page.
- R6: The attribute word at 0x220+4n holds eight 2-bit selectors. Selector k sits in bits 2k+1:2k and controls outAttr[k]. The outAttr bit order is three protection bits (0-2), four cache bits (3-6) and the non-secure bit (7). The selector codes are: 00 passes inAttr[k], 01 also passes, 10 forces 0, and 11 forces 1.
- R7: The general-purpose word at 0x2A0+4n keeps only bits 7:0. Those bits appear on `gpByte` when the region wins, and upper bits read back as zero.
- R8: On a lookup with no match, `hit`, `physAddr`, `outAttr` and `gpByte` are all zero. If `lookupValid` is high, the next edge sets status bit 0 at 0x008 and latches the address into 0x014.
- R9: While status is set, the captured address stays frozen. Writing 1 to bit 0 of 0x010 clears status. The next miss then captures its own address, and 0x010 reads as zero.
- R10: `irq` equals status bit 0 AND enable bit 0 of the word at 0x00C.
- R11: An array access whose region index is at or above 2^REGION_EXP is ignored on write and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 12 | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| lookupValid | input | 1 | Lookup qualifier for error capture |
| lookupAddr | input | 32 | Logical address to translate |
| inAttr | input | 8 | Incoming attribute bits |
| hit | output | 1 | An enabled region matched |
| physAddr | output | PA_W | Translated address |
| outAttr | output | 8 | Attribute bits after selectors |
| gpByte | output | 8 | Winning region's general-purpose byte |
| irq | output | 1 | Mismatch interrupt |

## Verification
The vector table programs three regions. Two of them overlap, one covers a single page with a negative add value, and a fourth covers everything but stays disabled.

The lookups are chosen to separate specific behaviours. An address in the overlap separates priority order from arbitrary selection. Addresses on the first and last page of a range separate inclusive from exclusive comparison. An address one page past a range and an address covered only by the disabled region each must miss. Attribute bytes of all ones, all zeros and alternating bits show whether each selector forces or passes its own bit.

Directed steps then cover the rest:
- a second miss while status is set, to check that the captured address stays frozen;
- interrupt masking;
- clear followed by a fresh capture;
- disabling a region so that an overlapping one takes over;
- truncation of the general-purpose byte;
- out-of-range region indices.

// File: rtl/atu_pkg.sv
package atu_pkg;

  typedef enum logic [2:0] {
    GRP_START = 3'd0,
    GRP_END   = 3'd1,
    GRP_ADDLO = 3'd2,
    GRP_ADDHI = 3'd3,
    GRP_ATTR  = 3'd4,
    GRP_GP    = 3'd5,
    GRP_NONE  = 3'd6
  } grp_e;

  // strobes from control to datapath: one decoded array access per cycle
  typedef struct packed {
    logic        wr;
    grp_e        grp;
    logic [4:0]  idx;
    logic [31:0] data;
  } arrAccess_t;

endpackage

// File: rtl/atu_ctrl.sv
module atu_ctrl
  import atu_pkg::*;
#(
  parameter int PAGE_EXP   = 12,
  parameter int REGION_EXP = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [11:0]               regAddr,
  input  logic                      regWrEn,
  input  logic [31:0]               regWrData,
  output logic [31:0]               regRdData,
  input  logic [31:0]               arrRdData,
  input  logic                      lookupValid,
  input  logic [31:0]               lookupAddr,
  input  logic                      hit,
  output arrAccess_t                acc,
  output logic [(1<<REGION_EXP)-1:0] regionEn,
  output logic                      irq
);
  localparam int NREG = 1 << REGION_EXP;

  logic [11:0] off;
  logic        inArr;
  logic        stReg, ieReg;
  logic [31:0] mmAddr;
  logic        missEv, clrEv;

  assign off   = regAddr - 12'h020;
  assign inArr = (regAddr >= 12'h020) && (off[11:10] == 2'b00) &&
                 (off[9:7] <= 3'd5) && (off[1:0] == 2'b00);

  always_comb begin
    acc.wr   = regWrEn && inArr;
    acc.grp  = inArr ? grp_e'(off[9:7]) : GRP_NONE;
    acc.idx  = off[6:2];
    acc.data = regWrData;
  end

  assign missEv = lookupValid && !hit;
  assign clrEv  = regWrEn && (regAddr == 12'h010) && regWrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regionEn <= '0;
      ieReg    <= 1'b0;
      stReg    <= 1'b0;
      mmAddr   <= '0;
    end else begin
      if (regWrEn && regAddr == 12'h004) regionEn <= regWrData[NREG-1:0];
      if (regWrEn && regAddr == 12'h00C) ieReg <= regWrData[0];
      if (missEv && (!stReg || clrEv)) mmAddr <= lookupAddr;
      stReg <= (stReg && !clrEv) || missEv;
    end
  end

  assign irq = stReg && ieReg;

  always_comb begin
    case (regAddr)
      12'h000: regRdData = 32'((PAGE_EXP << 4) | REGION_EXP);
      12'h004: regRdData = 32'(regionEn);
      12'h008: regRdData = {31'd0, stReg};
      12'h00C: regRdData = {31'd0, ieReg};
      12'h014: regRdData = mmAddr;
      default: regRdData = arrRdData;
    endcase
  end

  // R8
  miss_sets_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && !hit) |=> stReg);
  // R9
  clear_drops_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrEv && !missEv) |=> !stReg);
  // R9
  frozen_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stReg && !clrEv) |=> $stable(mmAddr));
endmodule

// File: rtl/atu_datapath.sv
module atu_datapath
  import atu_pkg::*;
#(
  parameter int PAGE_EXP   = 12,
  parameter int REGION_EXP = 2,
  parameter int PA_W       = 48
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  arrAccess_t                 acc,
  input  logic [(1<<REGION_EXP)-1:0] regionEn,
  output logic [31:0]                arrRdData,
  input  logic [31:0]                lookupAddr,
  input  logic [7:0]                 inAttr,
  output logic                       hit,
  output logic [PA_W-1:0]            physAddr,
  output logic [7:0]                 outAttr,
  output logic [7:0]                 gpByte
);
  localparam int NREG = 1 << REGION_EXP;
  localparam int PW   = 32 - PAGE_EXP;

  logic [PW-1:0] startPg [NREG];
  logic [PW-1:0] endPg   [NREG];
  logic [31:0]   addLo   [NREG];
  logic [31:0]   addHi   [NREG];
  logic [15:0]   attrSel [NREG];
  logic [7:0]    gpReg   [NREG];

  logic [NREG-1:0] match, win;
  logic [PW-1:0]   page;

  // region storage, one write port
  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (!rstN) begin
        startPg[r] <= '0; endPg[r] <= '0; addLo[r] <= '0;
        addHi[r] <= '0; attrSel[r] <= '0; gpReg[r] <= '0;
      end else if (acc.wr && acc.idx == 5'(r)) begin
        case (acc.grp)
          GRP_START: startPg[r] <= acc.data[PW-1:0];
          GRP_END:   endPg[r]   <= acc.data[PW-1:0];
          GRP_ADDLO: addLo[r]   <= acc.data;
          GRP_ADDHI: addHi[r]   <= acc.data;
          GRP_ATTR:  attrSel[r] <= acc.data[15:0];
          GRP_GP:    gpReg[r]   <= acc.data[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    arrRdData = '0;
    for (int r = 0; r < NREG; r++) begin
      if (acc.idx == 5'(r)) begin
        case (acc.grp)
          GRP_START: arrRdData = 32'(startPg[r]);
          GRP_END:   arrRdData = 32'(endPg[r]);
          GRP_ADDLO: arrRdData = addLo[r];
          GRP_ADDHI: arrRdData = addHi[r];
          GRP_ATTR:  arrRdData = 32'(attrSel[r]);
          GRP_GP:    arrRdData = 32'(gpReg[r]);
          default:   arrRdData = '0;
        endcase
      end
    end
  end

  assign page = lookupAddr[31:PAGE_EXP];

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign match[g] = regionEn[g] && (page >= startPg[g]) && (page <= endPg[g]);
  end

  // lowest index wins
  always_comb begin
    logic found;
    found = 1'b0;
    win   = '0;
    for (int r = 0; r < NREG; r++) begin
      win[r] = match[r] && !found;
      found  = found || match[r];
    end
  end

  always_comb begin
    logic [63:0]   addSel;
    logic [15:0]   selW;
    logic [PA_W-1:0] addShift;
    addSel = '0;
    selW   = '0;
    gpByte = '0;
    for (int r = 0; r < NREG; r++) begin
      if (win[r]) begin
        addSel = {addHi[r], addLo[r]};
        selW   = attrSel[r];
        gpByte = gpReg[r];
      end
    end
    hit      = |match;
    addShift = PA_W'(addSel << PAGE_EXP);
    physAddr = hit ? (PA_W'(lookupAddr) + addShift) : '0;
    for (int k = 0; k < 8; k++) begin
      case (selW[2*k +: 2])
        2'b10:   outAttr[k] = 1'b0;
        2'b11:   outAttr[k] = 1'b1;
        default: outAttr[k] = inAttr[k];
      endcase
      if (!hit) outAttr[k] = 1'b0;
    end
  end

  // R4
  winner_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(win) && ((win == '0) == (match == '0)));
endmodule

// File: rtl/atu_top.sv
module atu_top
  import atu_pkg::*;
#(
  parameter int PAGE_EXP   = 12,
  parameter int REGION_EXP = 2,
  parameter int PA_W       = 48
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [11:0]     regAddr,
  input  logic            regWrEn,
  input  logic [31:0]     regWrData,
  output logic [31:0]     regRdData,
  input  logic            lookupValid,
  input  logic [31:0]     lookupAddr,
  input  logic [7:0]      inAttr,
  output logic            hit,
  output logic [PA_W-1:0] physAddr,
  output logic [7:0]      outAttr,
  output logic [7:0]      gpByte,
  output logic            irq
);
  arrAccess_t                 acc;
  logic [(1<<REGION_EXP)-1:0] regionEn;
  logic [31:0]                arrRdData;

  atu_ctrl #(.PAGE_EXP(PAGE_EXP), .REGION_EXP(REGION_EXP)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .arrRdData(arrRdData),
    .lookupValid(lookupValid), .lookupAddr(lookupAddr), .hit(hit),
    .acc(acc), .regionEn(regionEn), .irq(irq));

  atu_datapath #(.PAGE_EXP(PAGE_EXP), .REGION_EXP(REGION_EXP), .PA_W(PA_W)) u_dp (
    .clk(clk), .rstN(rstN), .acc(acc), .regionEn(regionEn),
    .arrRdData(arrRdData), .lookupAddr(lookupAddr), .inAttr(inAttr),
    .hit(hit), .physAddr(physAddr), .outAttr(outAttr), .gpByte(gpByte));
endmodule

// File: tb/sim_atu_top.sv
`timescale 1ns/100ps
module sim_atu_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupAddr = '0;
  logic [7:0]  inAttr = '0;
  logic        hit;
  logic [47:0] physAddr;
  logic [7:0]  outAttr, gpByte;
  logic        irq;

  int nChk = 0, nBad = 0;

  always #2.5 clk = ~clk;

  atu_top u0 (.*);

  // addr, inAttr, hit, phys, attr, gp
  localparam logic [104:0] VEC [8] = '{
    {32'h0001_0004, 8'h00, 1'b1, 48'h0000_0011_0004, 8'h80, 8'hA5},
    {32'h0001_8000, 8'hFF, 1'b1, 48'h0000_0011_8000, 8'hFF, 8'hA5},
    {32'h0002_0010, 8'hFF, 1'b1, 48'h1000_0002_0010, 8'hF0, 8'h3C},
    {32'h0003_0FFF, 8'h0F, 1'b1, 48'h1000_0003_0FFF, 8'h00, 8'h3C},
    {32'h0003_1000, 8'hFF, 1'b0, 48'h0,              8'h00, 8'h00},
    {32'h0010_0800, 8'h55, 1'b1, 48'h0000_000F_F800, 8'h55, 8'h5A},
    {32'h0000_F000, 8'hFF, 1'b0, 48'h0,              8'h00, 8'h00},
    {32'h0001_0000, 8'h00, 1'b1, 48'h0000_0011_0000, 8'h80, 8'hA5}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic look(input logic [31:0] a, input logic [7:0] at);
    @(negedge clk);
    lookupAddr = a; inAttr = at; lookupValid = 1'b1;
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    nBad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state and build word
    rd(12'h000, d); chk("R1 build", 64'(d), 64'h0000_00C2);
    rd(12'h004, d); chk("R1 enable reset", 64'(d), 64'h0);
    rd(12'h020, d); chk("R1 start reset", 64'(d), 64'h0);
    rd(12'h008, d); chk("R1 status reset", 64'(d), 64'h0);
    chk("R1 irq reset", 64'(irq), 64'h0);
    chk("R1 hit reset", 64'(hit), 64'h0);

    // program regions
    wr(12'h020, 32'h10);  wr(12'h0A0, 32'h1F);  wr(12'h120, 32'h100);
    wr(12'h1A0, 32'h0);   wr(12'h220, 32'hC000); wr(12'h2A0, 32'hA5);
    wr(12'h024, 32'h18);  wr(12'h0A4, 32'h30);  wr(12'h124, 32'h0);
    wr(12'h1A4, 32'h1);   wr(12'h224, 32'h00AA); wr(12'h2A4, 32'h3C);
    wr(12'h028, 32'h100); wr(12'h0A8, 32'h100); wr(12'h128, 32'hFFFF_FFFF);
    wr(12'h1A8, 32'hFFFF_FFFF); wr(12'h228, 32'h5555); wr(12'h2A8, 32'h5A);
    wr(12'h02C, 32'h0);   wr(12'h0AC, 32'hF_FFFF);
    wr(12'h004, 32'h7);
    rd(12'h024, d); chk("R3 start readback", 64'(d), 64'h18);

    // R2 R3 R4 R5 R6 R7 R8 vector walk
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      lookupAddr = VEC[i][104:73]; inAttr = VEC[i][72:65]; lookupValid = 1'b1;
      #1;
      chk($sformatf("R3 R8 hit v%0d", i), 64'(hit), 64'(VEC[i][64]));
      chk($sformatf("R4 R5 phys v%0d", i), 64'(physAddr), 64'(VEC[i][63:16]));
      chk($sformatf("R6 attr v%0d", i), 64'(outAttr), 64'(VEC[i][15:8]));
      chk($sformatf("R7 gp v%0d", i), 64'(gpByte), 64'(VEC[i][7:0]));
    end
    @(negedge clk); lookupValid = 1'b0;

    // R8 R9 first miss captured, second frozen
    rd(12'h008, d); chk("R8 status set", 64'(d), 64'h1);
    rd(12'h014, d); chk("R9 frozen capture", 64'(d), 64'h0003_1000);
    // R10 masked then enabled
    chk("R10 irq masked", 64'(irq), 64'h0);
    wr(12'h00C, 32'h1);
    chk("R10 irq enabled", 64'(irq), 64'h1);
    // R9 clear and recapture
    wr(12'h010, 32'h1);
    rd(12'h008, d); chk("R9 status cleared", 64'(d), 64'h0);
    chk("R10 irq after clear", 64'(irq), 64'h0);
    rd(12'h010, d); chk("R9 clear reads zero", 64'(d), 64'h0);
    look(32'h0000_0004, 8'h00);
    rd(12'h014, d); chk("R9 new capture", 64'(d), 64'h0000_0004);
    chk("R10 irq again", 64'(irq), 64'h1);

    // R2 disable region 0: overlap goes to region 1
    wr(12'h004, 32'h6);
    @(negedge clk); lookupAddr = 32'h0001_8000; inAttr = 8'h00; #1;
    chk("R2 disabled phys", 64'(physAddr), 64'h1000_0001_8000);
    chk("R2 disabled gp", 64'(gpByte), 64'h3C);
    @(negedge clk); lookupAddr = 32'h0001_0000; #1;
    chk("R2 disabled miss", 64'(hit), 64'h0);

    // R7 truncation
    wr(12'h2A0, 32'h1234_56A5);
    rd(12'h2A0, d); chk("R7 gp truncate", 64'(d), 64'hA5);
    // R11 out of range index
    wr(12'h2B4, 32'h77);
    rd(12'h2B4, d); chk("R11 oob gp", 64'(d), 64'h0);
    rd(12'h030, d); chk("R11 oob start", 64'(d), 64'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule